// File: doc/BRIEF.md
# Dual Elapsed/Remaining Minute-Second Timer

The block keeps two minutes:seconds time values in BCD that advance together on one shared one-second tick. The elapsed value starts at 00:00 and counts up while the timer runs, so it shows total running time. The remaining value is loaded with a start time and counts down, so it shows the time left. When the remaining value reaches 00:00 it stays there and a sticky alarm output is raised.

The tick comes from an internal prescaler that counts clock cycles only while `run` is high. The number of cycles per tick is the parameter `TICK_DIV`. Its default of 5,000,000 gives one tick per second from a 5 MHz clock, and a test bench can set a small value. A single-cycle `load` strobe does four things: it copies a new start time into the remaining value, clears the elapsed value, clears the alarm and restarts the prescaler. Each time value is packed as four BCD digits `{minute tens, minute units, second tens, second units}` in bits `[15:12]`, `[11:8]`, `[7:4]` and `[3:0]`.

Top module: `dual_stopwatch_core`

## Requirements
- R1: While `rst` is high at a rising edge, `up_time`, `down_time`, `alarm` and the prescaler clear to zero. All outputs come straight from registers.
- R2: A `load` pulse that is sampled at an edge sets `down_time` to the clamped `init_time`, clears `up_time`, `alarm` and the prescaler, and cancels any tick that is pending. The new values are visible after that edge.
- R3: When `init_time` is loaded, any minute-tens, minute-units or second-units digit above 9 becomes 9, and any second-tens digit above 5 becomes 5.
- R4: With `run` held high from the edge after a load or restart, tick number k is generated at edge k*TICK_DIV. Both time values change at the following edge, so after edge k*TICK_DIV+1 they reflect k ticks.
- R5: While `run` is low, the prescaler count holds its value. The time values do not change except for a tick already pending, and counting resumes from the partial count that was held.
- R6: On each tick, `up_time` advances by one second. Second units carry 9→0, second tens carry 5→0, minute units carry 9→0, and 99:59 wraps to 00:00.
- R7: On each tick, a nonzero `down_time` goes back by one second. Second units borrow 0→9, second tens borrow 0→5, and minute units borrow 0→9 from the minute tens.
- R8: Once `down_time` is 00:00, it stays at 00:00 on later ticks until the next load.
- R9: `alarm` rises on the tick that moves `down_time` to 00:00, or on any tick while it is already 00:00. It stays high until reset or load, and it is only high while `down_time` is 00:00.
- R10: `up_time` keeps counting on every tick after the alarm has been raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables the prescaler, so timing advances while high |
| load | input | 1 | One-cycle strobe that loads the start time and clears the elapsed value and the alarm |
| init_time | input | 16 | Start time, BCD `{mt,mu,st,su}` |
| up_time | output | 16 | Elapsed time, BCD `{mt,mu,st,su}` |
| down_time | output | 16 | Remaining time, BCD `{mt,mu,st,su}` |
| alarm | output | 1 | Sticky flag raised when the remaining time reaches 00:00 |

## Verification
A load shows on every output one edge after it is sampled. A tick is raised at the edge that completes TICK_DIV run cycles and affects the outputs one edge later. The bench drives `run` for exactly k*TICK_DIV edges, drops it, lets one more edge pass and then samples on the falling edge, comparing against elapsed and remaining times computed arithmetically from k. The prescaler-clear and pause cases sample one cycle before a tick would fall due, so an early or a lost tick shows up as a wrong value.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

  typedef struct packed {
    logic [3:0] min_t;
    logic [3:0] min_u;
    logic [3:0] sec_t;
    logic [3:0] sec_u;
  } mmss_t;

  localparam logic [3:0] DEC_MAX = 4'd9;
  localparam logic [3:0] SEXT_MAX = 4'd5;

  function automatic logic [3:0] sat_digit(input logic [3:0] d, input logic [3:0] lim);
    return (d > lim) ? lim : d;
  endfunction

  function automatic mmss_t clamp_mmss(input mmss_t v);
    mmss_t r;
    r.min_t = sat_digit(v.min_t, DEC_MAX);
    r.min_u = sat_digit(v.min_u, DEC_MAX);
    r.sec_t = sat_digit(v.sec_t, SEXT_MAX);
    r.sec_u = sat_digit(v.sec_u, DEC_MAX);
    return r;
  endfunction

endpackage

// File: rtl/dsw_tick_gen.sv
module dsw_tick_gen #(
  parameter int TICK_DIV = 5000000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (run) begin
        if (cnt_q == LAST) begin
          cnt_q <= '0;
          tick  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dsw_up_counter.sv
module dsw_up_counter
  import dsw_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  clear,
  input  logic  tick,
  output mmss_t value
);
  mmss_t nxt;

  always_comb begin
    nxt = value;
    if (value.sec_u == DEC_MAX) begin
      nxt.sec_u = '0;
      if (value.sec_t == SEXT_MAX) begin
        nxt.sec_t = '0;
        if (value.min_u == DEC_MAX) begin
          nxt.min_u = '0;
          nxt.min_t = (value.min_t == DEC_MAX) ? 4'd0 : value.min_t + 4'd1;
        end else begin
          nxt.min_u = value.min_u + 4'd1;
        end
      end else begin
        nxt.sec_t = value.sec_t + 4'd1;
      end
    end else begin
      nxt.sec_u = value.sec_u + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) value <= '0;
    else if (tick)    value <= nxt;
  end
endmodule

// File: rtl/dsw_down_counter.sv
module dsw_down_counter
  import dsw_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  mmss_t load_val,
  input  logic  tick,
  output mmss_t value,
  output logic  alarm
);
  localparam mmss_t ONE_SEC = '{min_t: 4'd0, min_u: 4'd0, sec_t: 4'd0, sec_u: 4'd1};

  mmss_t nxt;
  logic  at_zero;
  logic  hits_zero;

  assign at_zero   = (value == '0);
  assign hits_zero = at_zero || (value == ONE_SEC);

  always_comb begin
    nxt = value;
    if (!at_zero) begin
      if (value.sec_u == 4'd0) begin
        nxt.sec_u = DEC_MAX;
        if (value.sec_t == 4'd0) begin
          nxt.sec_t = SEXT_MAX;
          if (value.min_u == 4'd0) begin
            nxt.min_u = DEC_MAX;
            nxt.min_t = value.min_t - 4'd1;
          end else begin
            nxt.min_u = value.min_u - 4'd1;
          end
        end else begin
          nxt.sec_t = value.sec_t - 4'd1;
        end
      end else begin
        nxt.sec_u = value.sec_u - 4'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
      alarm <= 1'b0;
    end else if (load) begin
      value <= clamp_mmss(load_val);
      alarm <= 1'b0;
    end else if (tick) begin
      value <= nxt;
      if (hits_zero) alarm <= 1'b1;
    end
  end
endmodule

// File: rtl/dual_stopwatch_core.sv
module dual_stopwatch_core
  import dsw_pkg::*;
#(
  parameter int TICK_DIV = 5000000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        run,
  input  logic        load,
  input  logic [15:0] init_time,
  output logic [15:0] up_time,
  output logic [15:0] down_time,
  output logic        alarm
);
  logic  tick;
  mmss_t up_v;
  mmss_t dn_v;

  dsw_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (load),
    .tick    (tick)
  );

  dsw_up_counter u_up (
    .clk   (clk),
    .rst   (rst),
    .clear (load),
    .tick  (tick),
    .value (up_v)
  );

  dsw_down_counter u_down (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (mmss_t'(init_time)),
    .tick     (tick),
    .value    (dn_v),
    .alarm    (alarm)
  );

  assign up_time   = up_v;
  assign down_time = dn_v;
endmodule

// File: rtl/dsw_checker.sv
module dsw_checker (
  input logic        clk,
  input logic        rst,
  input logic        run,
  input logic        load,
  input logic [15:0] up_time,
  input logic [15:0] down_time,
  input logic        alarm
);
  assert_load_clears_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (up_time == 16'h0000 && !alarm));

  assert_bcd_digits_R6: assert property (@(posedge clk) disable iff (rst)
    (up_time[3:0] <= 4'd9 && up_time[7:4] <= 4'd5 &&
     up_time[11:8] <= 4'd9 && up_time[15:12] <= 4'd9));

  assert_down_bcd_R3: assert property (@(posedge clk) disable iff (rst)
    (down_time[3:0] <= 4'd9 && down_time[7:4] <= 4'd5 &&
     down_time[11:8] <= 4'd9 && down_time[15:12] <= 4'd9));

  assert_floor_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (down_time == 16'h0000 && !load) |=> (down_time == 16'h0000));

  assert_alarm_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (alarm && !load) |=> alarm);

  assert_alarm_only_at_zero_R9: assert property (@(posedge clk) disable iff (rst)
    alarm |-> (down_time == 16'h0000));

  assert_idle_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(load) && !$past(run, 2)) |-> ($stable(up_time) && $stable(down_time)));
endmodule

bind dual_stopwatch_core dsw_checker u_dsw_checker (
  .clk       (clk),
  .rst       (rst),
  .run       (run),
  .load      (load),
  .up_time   (up_time),
  .down_time (down_time),
  .alarm     (alarm)
);

// File: tb/tb_dual_stopwatch_core.sv
`timescale 1ns/1ps
module tb_dual_stopwatch_core;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst;
  logic        run;
  logic        load;
  logic [15:0] init_time;
  logic [15:0] up_time;
  logic [15:0] down_time;
  logic        alarm;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  dual_stopwatch_core #(.TICK_DIV(DIV)) dut (
    .clk       (clk),
    .rst       (rst),
    .run       (run),
    .load      (load),
    .init_time (init_time),
    .up_time   (up_time),
    .down_time (down_time),
    .alarm     (alarm)
  );

  function automatic logic [15:0] to_bcd(input int secs);
    int m;
    int s;
    m = secs / 60;
    s = secs % 60;
    return {4'(m / 10), 4'(m % 10), 4'(s / 10), 4'(s % 10)};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected state after k ticks from a load of start seconds
  task automatic verify(input string req, input int k, input int start);
    int left;
    left = (start - k > 0) ? start - k : 0;
    check({req, " up"}, up_time, to_bcd(k % 6000));
    check({req, " down"}, down_time, to_bcd(left));
    check({req, " alarm"}, {15'd0, alarm}, {15'd0, (k > 0 && k >= start)});
  endtask

  task automatic do_load(input logic [15:0] v);
    @(negedge clk);
    init_time = v;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic run_cycles(input int n);
    @(negedge clk);
    run = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    run = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; run = 1'b0; load = 1'b0; init_time = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    verify("R1 reset", 0, 0);
    rst = 1'b0;

    // R2: load 10:30
    do_load(16'h1030);
    verify("R2 load", 0, 630);

    // R4 R6 R7 R8 R9 R10: tick-by-tick to the alarm and beyond
    for (int k = 1; k <= 635; k++) begin
      run_cycles(DIV);
      verify("R4 R6 R7 R9 countdown", k, 630);
    end
    // R10: up counting continues after alarm
    check("R10 up after alarm", up_time, 16'h1035);
    check("R8 floor", down_time, 16'h0000);

    // R2: load clears alarm and up value
    do_load(16'h0002);
    verify("R2 reload", 0, 2);

    // R2: load restarts prescaler
    run_cycles(2);
    do_load(16'h0002);
    run_cycles(DIV - 1);
    verify("R2 prescaler cleared", 0, 2);
    run_cycles(1);
    verify("R2 prescaler tick", 1, 2);

    // R5: pause holds partial count
    do_load(16'h0100);
    run_cycles(2);
    repeat (10) @(negedge clk);
    verify("R5 paused", 0, 60);
    run_cycles(DIV - 3);
    verify("R5 resume partial", 0, 60);
    run_cycles(1);
    verify("R5 resume tick", 1, 60);
    run_cycles(DIV);
    verify("R7 borrow min", 2, 60);

    // R3: clamp of invalid digits
    do_load(16'hFFFF);
    check("R3 clamp all", down_time, 16'h9959);
    do_load(16'h0A7C);
    check("R3 clamp mixed", down_time, 16'h0959);

    // R9: load of zero raises alarm on first tick
    do_load(16'h0000);
    verify("R9 zero load", 0, 0);
    run_cycles(DIV);
    verify("R9 zero tick", 1, 0);

    // R6: wrap of elapsed value at 99:59
    do_load(16'h9959);
    run_cycles(5999 * DIV);
    verify("R6 at 99:59", 5999, 5999);
    run_cycles(DIV);
    verify("R6 wrap", 6000, 5999);
    check("R6 wrap zero", up_time, 16'h0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule